// File: doc/BRIEF.md
# Multi-Context Interrupt Arbiter with Claim and Complete

This block collects a set of external interrupt inputs and distributes them to several target contexts. Each source goes through a gateway that turns a level or a rising edge into a single pending request. The gateway then blocks further requests from that source until the request has been serviced. Each context sees only the sources it has enabled and only those whose priority reaches its threshold. For each context the block drives one interrupt line that is high while any such source is pending.

A context services an interrupt by reading its claim word. The read returns the identifier of the best eligible source, clears that source's pending bit and marks the source as in service. When the handler finishes, the context writes the same identifier back to the claim word. That write ends the service period.

Edge sources come in two build-time flavours. In one, edges that arrive during service are counted in a small saturating counter and replayed one per completion. In the other, those edges are discarded.

All configuration goes through a word-addressed register port. That port accepts every request and returns read data one cycle later.

Top module: `ctx_irq_arbiter`

## Requirements
- R1: After reset every interrupt line is low, every priority, enable, threshold, trigger and pending bit is zero, and a claim read returns 0.
- R2: Word address i (1..NSRC) holds the priority of source i in its low PRIO_W bits. Address 0x20 is a read-only pending bitmap with bit i for source i. Address 0x21 is the trigger bitmap, where bit i = 1 selects edge mode for source i. For context c, the enable mask is at 0x40+4c (bit i enables source i), the threshold is at 0x41+4c and the claim/complete word is at 0x42+4c.
- R3: A claim read returns the ID of the eligible source with the highest priority, and on equal priority the lowest ID. The read clears that source's pending bit and puts the source in service.
- R4: A source is eligible for a context when it is pending, is enabled for that context and has a nonzero priority that reaches the threshold. irqOut[c] is high exactly while some source is eligible for context c. A claim read with no eligible source returns 0 and changes nothing.
- R5: A source whose priority is below a context's threshold does not raise that context's line and is not returned by its claim. A priority equal to the threshold is eligible.
- R6: A source that is not enabled for a context is invisible to that context, while other contexts that enable it still see it.
- R7: Writing a source ID to a claim/complete word ends that source's service. A write naming a source that is not in service has no effect. A source in service never becomes pending.
- R8: A level source becomes pending while its input is high and it is neither pending nor in service. It stays pending after its input falls. After completion it pends again if its input is still high.
- R9: An edge source becomes pending on a rising edge. With QUEUE_EDGES=1, rising edges seen while the source is pending or in service are counted, saturating at 15. Each completion with a nonzero count re-raises pending and decrements the count. With QUEUE_EDGES=0 those edges are dropped.
- R10: reqReady is always high. rspValid is high exactly one cycle after an accepted read, with rspData holding the value at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NSRC | Interrupt inputs; bit k is source ID k+1 |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Register request accepted (always 1) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Word address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after the read |
| rspData | output | 32 | Read data |
| irqOut | output | NCTX | One interrupt line per context |

## Verification
Several corner cases get directed tests. Two sources tie on priority, and a design that picks the higher ID fails the claim check. A priority equal to the threshold must count as eligible, and a priority-0 source stays pending but is never returned. A completion naming a source that is not in service must be ignored; a design that cleared state blindly would lose or invent pending bits. A level source must re-pend after completion while its input is held high and stay pending after its input drops. Queued edges must be replayed exactly as many times as were counted, up to the saturation limit of 15, and a second instance built in drop mode must replay none. Randomized rounds of priorities, masks, thresholds and inputs then compare each claim result and each interrupt line against a reference computed in the bench.

// File: rtl/ctx_irq_pkg.sv
package ctx_irq_pkg;
  localparam int ID_W   = 5;
  localparam int CTX_W  = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] PEND_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] TRIG_ADDR = 8'h21;
  localparam logic [2:0]        CTX_PAGE  = 3'b010;  // 0x40..0x5F

  typedef enum logic [2:0] {
    RD_ZERO, RD_PRIO, RD_PEND, RD_TRIG, RD_EN, RD_THR, RD_CLAIM
  } rdKind_e;

  typedef struct packed {
    logic              prioWe;
    logic              trigWe;
    logic              enWe;
    logic              thrWe;
    logic              claimRd;
    logic              complWe;
    logic [ID_W-1:0]   srcIdx;
    logic [CTX_W-1:0]  ctxIdx;
    rdKind_e           rdKind;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/ctx_irq_ctrl.sv
module ctx_irq_ctrl
  import ctx_irq_pkg::*;
#(
  parameter int NSRC = 7,
  parameter int NCTX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rdValue,
  output strobe_t           strobe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam logic [ADDR_W-1:0] LAST_PRIO = ADDR_W'(NSRC);
  localparam logic [CTX_W-1:0]  LAST_CTX  = CTX_W'(NCTX - 1);

  logic wrAcc;
  logic rdAcc;

  assign wrAcc = reqValid & reqWrite;
  assign rdAcc = reqValid & ~reqWrite;

  always_comb begin
    strobe        = '0;
    strobe.wdata  = reqWdata;
    strobe.rdKind = RD_ZERO;
    if (reqAddr != '0 && reqAddr <= LAST_PRIO) begin
      strobe.rdKind = RD_PRIO;
      strobe.srcIdx = reqAddr[ID_W-1:0];
      strobe.prioWe = wrAcc;
    end else if (reqAddr == PEND_ADDR) begin
      strobe.rdKind = RD_PEND;
    end else if (reqAddr == TRIG_ADDR) begin
      strobe.rdKind = RD_TRIG;
      strobe.trigWe = wrAcc;
    end else if (reqAddr[7:5] == CTX_PAGE && reqAddr[4:2] <= LAST_CTX) begin
      strobe.ctxIdx = reqAddr[4:2];
      case (reqAddr[1:0])
        2'd0: begin
          strobe.rdKind = RD_EN;
          strobe.enWe   = wrAcc;
        end
        2'd1: begin
          strobe.rdKind = RD_THR;
          strobe.thrWe  = wrAcc;
        end
        2'd2: begin
          strobe.rdKind  = RD_CLAIM;
          strobe.claimRd = rdAcc;
          strobe.complWe = wrAcc;
        end
        default: strobe.rdKind = RD_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= rdAcc;
      if (rdAcc) rspData <= rdValue;
    end
  end
endmodule

// File: rtl/ctx_irq_dp.sv
module ctx_irq_dp
  import ctx_irq_pkg::*;
#(
  parameter int NSRC        = 7,
  parameter int NCTX        = 2,
  parameter int PRIO_W      = 3,
  parameter int CNT_W       = 4,
  parameter int QUEUE_EDGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] rdValue,
  output logic [NSRC:1]     pendVec,
  output logic [NSRC:1]     svcVec,
  output logic [NCTX-1:0]   irqOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRIO_W-1:0] prio [1:NSRC];
  logic [NSRC:1]     trigEdge;
  logic [NSRC:1]     enMask [NCTX];
  logic [PRIO_W-1:0] thr [NCTX];
  logic [ID_W-1:0]   bestId [NCTX];
  logic [ID_W-1:0]   claimId;

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigEdge <= '0;
      for (int i = 1; i <= NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        enMask[c] <= '0;
        thr[c]    <= '0;
      end
    end else begin
      if (strobe.trigWe) trigEdge <= strobe.wdata[NSRC:1];
      for (int i = 1; i <= NSRC; i++)
        if (strobe.prioWe && strobe.srcIdx == ID_W'(i)) prio[i] <= strobe.wdata[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (strobe.enWe && strobe.ctxIdx == CTX_W'(c)) enMask[c] <= strobe.wdata[NSRC:1];
        if (strobe.thrWe && strobe.ctxIdx == CTX_W'(c)) thr[c] <= strobe.wdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    claimId = '0;
    for (int c = 0; c < NCTX; c++)
      if (strobe.ctxIdx == CTX_W'(c)) claimId = bestId[c];
  end

  // per-source gateways
  for (genvar g = 1; g <= NSRC; g++) begin : gGate
    logic             srcPrev, pend, svc, rise, req, busy, claimHit, complHit;
    logic [CNT_W-1:0] cnt, cntNext;

    assign rise     = srcIn[g-1] & ~srcPrev;
    assign req      = trigEdge[g] ? rise : srcIn[g-1];
    assign busy     = pend | svc;
    assign claimHit = strobe.claimRd && claimId == ID_W'(g);
    assign complHit = strobe.complWe && strobe.wdata == DATA_W'(g) && svc;

    if (QUEUE_EDGES != 0) begin : gQueue
      assign cntNext = (trigEdge[g] && rise && busy && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
    end else begin : gDrop
      assign cntNext = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcPrev <= 1'b0;
        pend    <= 1'b0;
        svc     <= 1'b0;
        cnt     <= '0;
      end else begin
        srcPrev <= srcIn[g-1];
        cnt     <= cntNext;
        if (claimHit) begin
          pend <= 1'b0;
          svc  <= 1'b1;
        end else if (complHit) begin
          svc <= 1'b0;
          if (cntNext != '0) begin
            pend <= 1'b1;
            cnt  <= cntNext - 1'b1;
          end
        end else if (req && !busy) begin
          pend <= 1'b1;
        end
      end
    end

    assign pendVec[g] = pend;
    assign svcVec[g]  = svc;
  end

  // per-context arbitration: highest priority, lowest ID on ties
  for (genvar c = 0; c < NCTX; c++) begin : gArb
    logic [ID_W-1:0]   best;
    logic [PRIO_W-1:0] bestPrio;
    always_comb begin
      best     = '0;
      bestPrio = '0;
      for (int i = NSRC; i >= 1; i--)
        if (pendVec[i] && enMask[c][i] && prio[i] != '0 && prio[i] >= thr[c] && prio[i] >= bestPrio) begin
          best     = ID_W'(i);
          bestPrio = prio[i];
        end
    end
    assign bestId[c] = best;
    assign irqOut[c] = best != '0;
  end

  always_comb begin
    rdValue = '0;
    case (strobe.rdKind)
      RD_PRIO:
        for (int i = 1; i <= NSRC; i++)
          if (strobe.srcIdx == ID_W'(i)) rdValue = DATA_W'(prio[i]);
      RD_PEND: rdValue = DATA_W'({pendVec, 1'b0});
      RD_TRIG: rdValue = DATA_W'({trigEdge, 1'b0});
      RD_EN:
        for (int c = 0; c < NCTX; c++)
          if (strobe.ctxIdx == CTX_W'(c)) rdValue = DATA_W'({enMask[c], 1'b0});
      RD_THR:
        for (int c = 0; c < NCTX; c++)
          if (strobe.ctxIdx == CTX_W'(c)) rdValue = DATA_W'(thr[c]);
      RD_CLAIM: rdValue = DATA_W'(claimId);
      default: rdValue = '0;
    endcase
  end
endmodule

// File: rtl/ctx_irq_arbiter.sv
module ctx_irq_arbiter
  import ctx_irq_pkg::*;
#(
  parameter int NSRC        = 7,
  parameter int NCTX        = 2,
  parameter int PRIO_W      = 3,
  parameter int CNT_W       = 4,
  parameter int QUEUE_EDGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [NCTX-1:0]   irqOut
);
  strobe_t           strobe;
  logic [DATA_W-1:0] rdValue;
  logic [NSRC:1]     pendVec;
  logic [NSRC:1]     svcVec;

  assign reqReady = 1'b1;

  ctx_irq_ctrl #(.NSRC(NSRC), .NCTX(NCTX)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValue(rdValue),
    .strobe(strobe), .rspValid(rspValid), .rspData(rspData)
  );

  ctx_irq_dp #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .CNT_W(CNT_W), .QUEUE_EDGES(QUEUE_EDGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .rdValue(rdValue),
    .pendVec(pendVec), .svcVec(svcVec), .irqOut(irqOut)
  );
endmodule

// File: rtl/ctx_irq_checker.sv
module ctx_irq_checker #(
  parameter int NSRC = 7,
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqWrite,
  input logic [7:0]      reqAddr,
  input logic [31:0]     reqWdata,
  input logic            rspValid,
  input logic [31:0]     rspData,
  input logic [NSRC:1]   pendVec,
  input logic [NSRC:1]   svcVec,
  input logic [NCTX-1:0] irqOut
);
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN) (reqValid && !reqWrite) |=> rspValid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN) !(reqValid && !reqWrite) |=> !rspValid); // R10

  for (genvar k = 1; k <= NSRC; k++) begin : gSrc
    AST_CLAIM_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rstN) $rose(svcVec[k]) |-> ($past(pendVec[k]) && !pendVec[k])); // R3
    AST_SERVICE_ENDS_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rstN) $fell(svcVec[k]) |-> $past(reqValid && reqWrite && reqAddr[7:5] == 3'b010 && reqAddr[1:0] == 2'd2 && reqWdata == 32'(k))); // R7
    AST_PEND_SVC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(pendVec[k] && svcVec[k])); // R7
  end

  for (genvar c = 0; c < NCTX; c++) begin : gCtx
    AST_IDLE_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rstN) (reqValid && !reqWrite && reqAddr == 8'(8'h42 + 4 * c) && !irqOut[c]) |=> (rspData == 32'd0)); // R4
  end
endmodule

bind ctx_irq_arbiter ctx_irq_checker #(.NSRC(NSRC), .NCTX(NCTX)) uChk (.*);

// File: tb/tb_ctx_irq_arbiter.sv
`timescale 1ns/1ps
module tb_ctx_irq_arbiter;
  localparam int NSRC = 7;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspValid, reqReady2, rspValid2;
  logic [31:0] rspData, rspData2;
  logic [NCTX-1:0] irqOut, irqOut2;

  int checks = 0;
  int errors = 0;

  // model state for the random phase
  int prioM [1:NSRC];
  logic [7:0] enM [NCTX];
  int thrM [NCTX];
  logic [7:0] pendM;

  always #5 clk = ~clk;

  ctx_irq_arbiter #(.NSRC(NSRC), .NCTX(NCTX), .QUEUE_EDGES(1)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .irqOut(irqOut)
  );

  ctx_irq_arbiter #(.NSRC(NSRC), .NCTX(NCTX), .QUEUE_EDGES(0)) dutDrop (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .reqValid(reqValid), .reqReady(reqReady2),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid2), .rspData(rspData2), .irqOut(irqOut2)
  );

  function automatic logic [7:0] aEn(int c);  return 8'(8'h40 + 4 * c); endfunction
  function automatic logic [7:0] aThr(int c); return 8'(8'h41 + 4 * c); endfunction
  function automatic logic [7:0] aClm(int c); return 8'(8'h42 + 4 * c); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d2);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    d = rspData; d2 = rspData2;
    chk("R10 rspValid after read", 32'(rspValid), 32'd1);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R10 rspValid single cycle", 32'(rspValid), 32'd0);
  endtask

  task automatic pulse6();
    @(negedge clk); srcIn[5] = 1'b1;
    @(negedge clk); srcIn[5] = 1'b0;
  endtask

  function automatic int bestOf(int c);
    int b = 0;
    int bp = 0;
    for (int i = NSRC; i >= 1; i--)
      if (pendM[i] && enM[c][i] && prioM[i] != 0 && prioM[i] >= thrM[c] && prioM[i] >= bp) begin
        b = i; bp = prioM[i];
      end
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int reps;
    void'($urandom(32'd1234));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irqOut after reset", 32'(irqOut), 32'd0);
    chk("R10 reqReady", 32'(reqReady), 32'd1);
    rd(8'h20, d, d2); chk("R1 pending after reset", d, 32'd0);
    rd(aClm(0), d, d2); chk("R1 claim after reset", d, 32'd0);
    rd(8'h01, d, d2); chk("R1 priority after reset", d, 32'd0);

    // R2 register map
    wr(8'h03, 32'd5); rd(8'h03, d, d2); chk("R2 priority readback", d, 32'd5);
    wr(8'h03, 32'hFF); rd(8'h03, d, d2); chk("R2 priority width", d, 32'd7);
    wr(aThr(1), 32'd3); rd(aThr(1), d, d2); chk("R2 threshold readback", d, 32'd3);

    // directed level scenario
    wr(8'h01, 32'd4); wr(8'h02, 32'd6); wr(8'h03, 32'd6); wr(8'h04, 32'd2); wr(8'h05, 32'd0);
    wr(aEn(0), 32'hFE); wr(aEn(1), 32'h10); wr(aThr(0), 32'd0);
    rd(aEn(1), d, d2); chk("R2 enable readback", d, 32'h10);
    srcIn = 7'b0011111;
    idle(3);
    rd(8'h20, d, d2); chk("R8 pending bitmap level", d, 32'h3E);
    chk("R5 ctx1 line masked by threshold", 32'(irqOut[1]), 32'd0);
    chk("R4 ctx0 line high", 32'(irqOut[0]), 32'd1);
    rd(aClm(1), d, d2); chk("R5 claim below threshold", d, 32'd0);
    wr(aThr(1), 32'd2);
    chk("R5 priority equal threshold raises line", 32'(irqOut[1]), 32'd1);
    rd(aClm(1), d, d2); chk("R6 ctx1 claims only its enabled source", d, 32'd4);
    rd(aClm(0), d, d2); chk("R3 tie goes to lowest ID", d, 32'd2);
    rd(8'h20, d, d2); chk("R3 claim clears pending", d, 32'h2A);
    rd(aClm(0), d, d2); chk("R3 second of tie", d, 32'd3);
    rd(aClm(0), d, d2); chk("R3 next priority", d, 32'd1);
    rd(aClm(0), d, d2); chk("R4 priority zero never claimed", d, 32'd0);
    chk("R4 line low with only priority zero pending", 32'(irqOut[0]), 32'd0);

    // R7 bogus completions, R8 re-pend
    srcIn = 7'b0010001;
    wr(aClm(0), 32'd5); wr(aClm(0), 32'd6);
    idle(2);
    rd(8'h20, d, d2); chk("R7 bogus completion and in-service block", d, 32'h20);
    wr(aClm(0), 32'd2); wr(aClm(0), 32'd3); wr(aClm(1), 32'd4); wr(aClm(0), 32'd1);
    idle(2);
    rd(8'h20, d, d2); chk("R8 level re-pends after completion", d, 32'h22);
    srcIn = '0;
    rd(aClm(0), d, d2); chk("R3 claim re-pended level", d, 32'd1);
    wr(aClm(0), 32'd1);
    idle(2);
    rd(8'h20, d, d2); chk("R8 pending held after input falls", d, 32'h20);
    wr(8'h05, 32'd1);
    rd(aClm(0), d, d2); chk("R4 nonzero priority now claimable", d, 32'd5);
    wr(aClm(0), 32'd5);
    idle(2);
    rd(8'h20, d, d2); chk("R8 no re-pend with input low", d, 32'd0);

    // R9 edge gateways
    wr(8'h21, 32'h40); wr(8'h06, 32'd3);
    rd(8'h21, d, d2); chk("R2 trigger readback", d, 32'h40);
    pulse6(); idle(1);
    rd(8'h20, d, d2); chk("R9 edge sets pending", d, 32'h40);
    chk("R9 edge sets pending drop", d2, 32'h40);
    rd(aClm(0), d, d2); chk("R9 claim edge source", d, 32'd6);
    pulse6(); pulse6(); pulse6(); idle(1);
    rd(8'h20, d, d2); chk("R9 no pending during service", d, 32'd0);
    wr(aClm(0), 32'd6);
    rd(8'h20, d, d2); chk("R9 queued edge replayed", d, 32'h40);
    chk("R9 drop mode discards edges", d2, 32'd0);
    reps = 1;
    for (int k = 0; k < 10; k++) begin
      rd(aClm(0), d, d2);
      wr(aClm(0), 32'd6);
      rd(8'h20, d, d2);
      if (d[6]) reps++; else break;
    end
    chk("R9 replays equal queued edges", 32'(reps), 32'd3);

    pulse6(); idle(1);
    rd(aClm(0), d, d2); chk("R9 claim before saturation", d, 32'd6);
    for (int k = 0; k < 20; k++) pulse6();
    reps = 0;
    for (int k = 0; k < 30; k++) begin
      wr(aClm(0), 32'd6);
      rd(8'h20, d, d2);
      if (k == 0) chk("R9 drop mode after saturation burst", d2, 32'd0);
      if (d[6]) begin
        reps++;
        rd(aClm(0), d, d2);
      end else break;
    end
    chk("R9 counter saturates at 15", 32'(reps), 32'd15);
    wr(8'h21, 32'd0);

    // random rounds against the bench model
    pendM = '0;
    for (int r = 0; r < 25; r++) begin
      logic [NSRC-1:0] srcM;
      logic [7:0] svcM;
      svcM = '0;
      for (int i = 1; i <= NSRC; i++) begin
        prioM[i] = $urandom_range(0, 7);
        wr(8'(i), 32'(prioM[i]));
      end
      for (int c = 0; c < NCTX; c++) begin
        enM[c] = 8'($urandom) & 8'hFE;
        thrM[c] = $urandom_range(0, 7);
        wr(aEn(c), 32'(enM[c]));
        wr(aThr(c), 32'(thrM[c]));
      end
      srcM = 7'($urandom);
      srcIn = srcM;
      idle(3);
      pendM = pendM | {srcM, 1'b0};
      rd(8'h20, d, d2); chk("R8 random pending bitmap", d, 32'(pendM));
      for (int c = 0; c < NCTX; c++)
        chk("R4 random line", 32'(irqOut[c]), 32'(bestOf(c) != 0));
      for (int t = 0; t < 8; t++) begin
        int c;
        int e;
        c = $urandom_range(0, 1);
        e = bestOf(c);
        rd(aClm(c), d, d2);
        chk(c == 0 ? "R3 random claim ctx0" : "R6 random claim ctx1", d, 32'(e));
        if (e != 0) begin
          pendM[e] = 1'b0;
          svcM[e] = 1'b1;
        end
      end
      srcM = 7'($urandom);
      srcIn = srcM;
      for (int i = 1; i <= NSRC; i++)
        if (svcM[i]) wr(aClm(i % NCTX), 32'(i));
      idle(3);
      pendM = pendM | {srcM, 1'b0};
      rd(8'h20, d, d2); chk("R7 random pending after completions", d, 32'(pendM));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule